// File: doc/BRIEF.md
# Byte-wide Fuse Read Sequencer

This block reads a run of consecutive bytes out of a one-time-programmable fuse array whose macro is organised one byte per address. A host gives it a start byte offset, a byte count and a one-cycle start pulse. The block then runs a fixed pin-level sequence on the macro and returns each fuse byte on a data output, together with a one-cycle valid pulse. It raises busy while the sequence runs and pulses done at the end. It never programs fuses.

The macro pins are driven as one packed 16-bit control word. Every wait between pin changes lasts at least `CYCLES_PER_US` clock cycles, which is one microsecond at the target clock. A read has four parts:
- A load phase opens the read.
- Each byte then has an address phase, a strobe-high phase and a strobe-low phase.
- At the end the pins return to a standby state, with the array deselected and programming disabled.

Top module: `efuse_byte_reader`

## Requirements
- R1: Control word encoding on `fuse_ctrl`: bit 0 is the active-low chip select, bit 1 is strobe, bit 2 is load, bit 3 is the active-low program enable, bits 5:4 are zero and bits 15:6 carry the macro address. In reset and while idle the word is 16'h0009 (standby), and busy, done and rd_valid are low.
- R2: After a start with a nonzero count, busy rises. The word shows load=1, program enable=1, chip select=0 and strobe=0 for at least `CYCLES_PER_US` cycles before the first strobe. The address field is zero during that time.
- R3: For each byte, the address field is driven to zero for at least one cycle before the new address is driven. The address then holds stable for at least `CYCLES_PER_US` cycles before strobe rises.
- R4: Strobe stays high for at least `CYCLES_PER_US` cycles, and only while chip select is low. The macro data present at the end of that window appears on `rd_data` with `rd_valid` high for exactly one cycle.
- R5: After strobe falls, it stays low for at least `CYCLES_PER_US` cycles before the next address phase. The address changes only while strobe is low.
- R6: Byte i of a read comes from macro address (offset + i) mod 1024. Offset bits above bit 9 are ignored. Exactly `byte_count` bytes are returned, in ascending address order.
- R7: When the last byte's strobe-low wait ends, the control word returns to 16'h0009. Busy falls and done is high for exactly one cycle.
- R8: A start with a byte count of zero leaves busy low and returns no bytes. Done goes high for one cycle, in the cycle after the start is taken.
- R9: A start pulse while busy is high is ignored: the running read's bytes, addresses and count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle read request |
| start_offset | input | OFS_W | First byte offset (low 10 bits used) |
| byte_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured fuse byte |
| rd_valid | output | 1 | One-cycle qualifier for rd_data |
| fuse_ctrl | output | 16 | Packed macro control word (address and pins) |
| fuse_dout | input | 8 | Macro data output |

## Verification
The assertions assume that the macro data depends only on the address being driven and is stable by the end of the strobe-high window. They also assume that start is a clean synchronous pulse. The bench models the macro as a pure function of the address field, so data follows the address with no extra latency. It drives start, offset and count only on falling edges and holds offset and count steady through the start cycle. Pin timing is measured at the control-word port in whole cycles and compared against the minimum waits.

// File: rtl/efuse_byte_reader.sv
module efuse_byte_reader #(
  parameter int CYCLES_PER_US = 4,
  parameter int OFS_W         = 16,
  parameter int CNT_W         = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFS_W-1:0] start_offset,
  input  logic [CNT_W-1:0] byte_count,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic [15:0]      fuse_ctrl,
  input  logic [7:0]       fuse_dout
);
  localparam int AW = 10;
  localparam int TW = $clog2(CYCLES_PER_US + 1);
  localparam logic [TW-1:0] T_LAST = TW'(CYCLES_PER_US - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ACLR, S_ASET, S_STBH, S_STBL} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [AW-1:0]    cur;
  logic [CNT_W-1:0] rem;
  logic             wait_end;
  logic             addr_on;
  logic [AW-1:0]    addr_drv;

  assign wait_end = (tmr == T_LAST);
  assign busy     = (st != S_IDLE);
  assign addr_on  = (st == S_ASET) || (st == S_STBH) || (st == S_STBL);
  assign addr_drv = addr_on ? cur : '0;

  assign fuse_ctrl = {addr_drv, 2'b00, 1'b1, busy, st == S_STBH, !busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      cur      <= '0;
      rem      <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      tmr      <= wait_end ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: begin
          tmr <= '0;
          if (start) begin
            if (byte_count == '0) begin
              done <= 1'b1;
            end else begin
              st  <= S_LOAD;
              cur <= start_offset[AW-1:0];
              rem <= byte_count;
            end
          end
        end
        S_LOAD: if (wait_end) st <= S_ACLR;
        S_ACLR: begin
          tmr <= '0;
          st  <= S_ASET;
        end
        S_ASET: if (wait_end) st <= S_STBH;
        S_STBH: if (wait_end) begin
          rd_data  <= fuse_dout;
          rd_valid <= 1'b1;
          rem      <= rem - 1'b1;
          st       <= S_STBL;
        end
        S_STBL: if (wait_end) begin
          cur <= cur + 1'b1;
          if (rem == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_ACLR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> fuse_ctrl == 16'h0009);
  // R4
  strobe_csb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_ctrl[1] |-> !fuse_ctrl[0]);
  // R3
  addr_stable_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_ctrl[1]) |-> $stable(fuse_ctrl[15:6]));
  // R5
  addr_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fuse_ctrl[15:6]) |-> !fuse_ctrl[1]);
  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);
endmodule

// File: tb/sim_efuse_byte_reader.sv
module sim_efuse_byte_reader;
  localparam int CLK_PERIOD = 10;
  localparam int CYC = 4;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [15:0] start_offset = 0;
  logic [10:0] byte_count = 0;
  logic        busy, done, rd_valid;
  logic [7:0]  rd_data, fuse_dout;
  logic [15:0] fuse_ctrl;

  int compared = 0, mismatched = 0;
  logic [7:0] got [0:31];
  int got_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [9:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd37 + 16'(a >> 3);
    return t[7:0] ^ 8'hA5;
  endfunction

  assign fuse_dout = pat(fuse_ctrl[15:6]);

  efuse_byte_reader #(.CYCLES_PER_US(CYC), .OFS_W(16), .CNT_W(11)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
    .byte_count(byte_count), .busy(busy), .done(done), .rd_data(rd_data),
    .rd_valid(rd_valid), .fuse_ctrl(fuse_ctrl), .fuse_dout(fuse_dout));

  task automatic check(input string req, input bit ok, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [15:0] p_ctrl = 16'h0009;
  int hi_run = 0, low_run = 0, since_csb = 0, a_run = 0;
  bit first = 0;
  always @(negedge clk) if (rst_n) begin
    if (rd_valid && got_n < 32) begin
      got[got_n] = rd_data;
      got_n++;
    end
    if (p_ctrl[0] && !fuse_ctrl[0]) first = 1;
    if (fuse_ctrl[1] && !p_ctrl[1]) begin
      if (first) begin
        check("R2 load wait", since_csb >= 2*CYC+1, since_csb, 2*CYC+1);
        check("R2 load pins", p_ctrl[3:2] == 2'b11 && !p_ctrl[0], int'(p_ctrl[3:0]), 12);
        first = 0;
      end else begin
        check("R5 strobe low", low_run >= 2*CYC+1, low_run, 2*CYC+1);
      end
      check("R3 addr setup", a_run >= CYC, a_run, CYC);
    end
    if (!fuse_ctrl[1] && p_ctrl[1])
      check("R4 strobe high", hi_run >= CYC, hi_run, CYC);
    if (busy && fuse_ctrl[15:6] != p_ctrl[15:6])
      check("R3 addr clear", fuse_ctrl[15:6] == 0 || p_ctrl[15:6] == 0,
            int'(fuse_ctrl[15:6]), 0);
    hi_run    = fuse_ctrl[1] ? hi_run + 1 : 0;
    low_run   = fuse_ctrl[1] ? 0 : low_run + 1;
    since_csb = fuse_ctrl[0] ? 0 : since_csb + 1;
    a_run     = (fuse_ctrl[15:6] == p_ctrl[15:6]) ? a_run + 1 : 1;
    p_ctrl    = fuse_ctrl;
  end

  task automatic pulse_start(input logic [15:0] ofs, input logic [10:0] cnt);
    @(negedge clk);
    start = 1; start_offset = ofs; byte_count = cnt;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_read(input logic [15:0] ofs, input logic [10:0] cnt, input bit poke);
    bit ok;
    logic [9:0] base;
    got_n = 0;
    base = ofs[9:0];
    pulse_start(ofs, cnt);
    check("R2 busy", busy == 1, busy, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1; start_offset = 16'd500; byte_count = 11'd1;
      @(negedge clk);
      start = 0;
    end
    wait_done(ok);
    check("R7 done seen", ok, ok, 1);
    check("R7 standby", fuse_ctrl == 16'h0009 && !busy, int'(fuse_ctrl), 9);
    check(poke ? "R9 count" : "R6 count", got_n == cnt, got_n, cnt);
    for (int i = 0; i < got_n && i < 32; i++)
      check(poke ? "R9 data" : "R6 data", got[i] == pat(base + 10'(i)),
            got[i], pat(base + 10'(i)));
    @(negedge clk);
    check("R7 done pulse", done == 0, done, 0);
  endtask

  localparam logic [26:0] VEC [0:4] = '{
    {16'd0, 11'd1}, {16'd5, 11'd3}, {16'd1022, 11'd4},
    {16'hFC03, 11'd2}, {16'd200, 11'd9}};

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ctrl", fuse_ctrl == 16'h0009, int'(fuse_ctrl), 9);
    check("R1 reset flags", !busy && !done && !rd_valid, int'({busy, done, rd_valid}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle ctrl", fuse_ctrl == 16'h0009, int'(fuse_ctrl), 9);

    for (int v = 0; v < 5; v++)
      run_read(VEC[v][26:11], VEC[v][10:0], 0);

    // R8 zero count
    got_n = 0;
    pulse_start(16'd77, 11'd0);
    check("R8 done", done == 1, done, 1);
    check("R8 busy", busy == 0, busy, 0);
    @(negedge clk);
    check("R8 done width", done == 0, done, 0);
    repeat (20) @(negedge clk);
    check("R8 no bytes", got_n == 0, got_n, 0);
    check("R8 standby", fuse_ctrl == 16'h0009, int'(fuse_ctrl), 9);

    // R9 start while busy
    run_read(16'd100, 11'd3, 1);
    repeat (30) @(negedge clk);
    check("R9 no extra", got_n == 3 && !busy, got_n, 3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule